// File: doc/BRIEF.md
# SPI Master Command-Queue Engine

This block is a register-programmed SPI master that works through a short queue of command words. Software writes 32-bit commands into a four-entry transmit FIFO. Each command carries the frame data and its own per-frame controls:

- which peripheral selects to drive,
- which of four attribute sets to use,
- whether the select stays asserted after the frame,
- whether the frame ends the queue,
- whether the completed-frame counter restarts.

The engine takes one command at a time. It shifts the frame with the chosen attribute set, which gives the frame length, clock polarity, clock phase, bit order and bit rate. The received word goes into a four-entry receive FIFO, and software pops it from there.

When a frame marked end-of-queue finishes, the engine raises a sticky completion flag and stops taking commands until software clears the flag. It can also raise an interrupt. Peripheral-select pins idle at a level that software programs, and they go to the opposite level while selected. Software reaches every register through a simple address/data bus with single-cycle write and read strobes. Reads are combinational, and a read of the pop address removes one entry.

Top module: `spi_cmdq_master`

## Requirements
- R1: After reset, every select pin is high (the idle-level field in control bits 21:16 resets to all ones), SCK is 0, irq is 0 and the status register (0x2C) reads 0.
- R2: Each frame is fsz+1 bits long, where fsz is attribute bits 30:27 (values 3 to 15 give 4 to 16 bits). The data sent is command bits 15:0, most significant bit first, or least significant bit first when attribute bit 24 is set. The bits received are assembled in the same order and read back from bits 15:0 of the pop register (0x38).
- R3: SCK rests at the CPOL level (attribute bit 26) between frames. With CPHA (attribute bit 25) at 0, data is captured on the first SCK edge after select assertion. With CPHA at 1, data is captured on the second edge.
- R4: Command bits 21:16 choose the select pins driven active during the frame, and command bits 29:28 choose the attribute register (0x0C + 4*index). A selected pin is driven to the inverse of its idle-level bit.
- R5: With command bit 31 set, the select stays active after the frame until the next frame. With the bit clear, or on an end-of-queue frame, the select returns to idle after the frame.
- R6: When a frame whose command has bit 27 set completes, status bit 28 is set. While that bit is set, no further command is taken. Writing 1 to status bit 28 clears it.
- R7: irq is high exactly when status bit 28 and interrupt-enable bit 28 (register 0x30) are both set.
- R8: Status bits 15:0 count completed frames. A command with bit 26 set restarts the count, so that frame completes with a count of 1.
- R9: The transmit FIFO holds 4 commands, written at 0x34. A write to a full FIFO is dropped.
- R10: The receive FIFO holds 4 words. The engine does not start a frame while the FIFO is full. A pop from an empty FIFO returns 0 and changes no state.
- R11: No frame starts while control bit 31 is clear. Writing 1 to control bit 11 empties the transmit FIFO, and writing 1 to bit 10 empties the receive FIFO. Both are one-shot actions.
- R12: The SCK half period is P*S/2 clock cycles. P comes from {2,3,5,7} indexed by attribute bits 17:16. S is 2*(n+1) for a scaler code n (attribute bits 3:0) below 4, and 2^n otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops when at 0x38) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_pin | output | 6 | Peripheral select pins |
| irq | output | 1 | Completion interrupt |

## Verification
A behavioural slave model drives MISO from a known per-frame word and captures MOSI on the edges that the bench's own mode settings dictate. The four mode combinations, the frame lengths 4, 8, 12 and 16, and both bit orders are each run. A mismatch therefore separates a wrong sampling edge from a wrong bit order or a wrong length mask. Queues are run with and without continuous select, so that counting select releases distinguishes held selects from per-frame selects. Other queues carry end-of-queue frames back to back, to show that the halt happens. Overflow and stall patterns fill the transmit FIFO past four entries and leave the receive FIFO unread. Flush and run-gate sequences confirm that no frame escapes while the engine is held.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;

    localparam int NUM_SS    = 6;
    localparam int FRAME_W   = 16;
    localparam int HALF_W    = 17;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_ATTR0 = 8'h0C;
    localparam logic [7:0] A_STAT  = 8'h2C;
    localparam logic [7:0] A_IEN   = 8'h30;
    localparam logic [7:0] A_PUSH  = 8'h34;
    localparam logic [7:0] A_POP   = 8'h38;

    typedef struct packed {
        logic [3:0] fsz;
        logic       cpol;
        logic       cpha;
        logic       lsb;
        logic [1:0] pre;
        logic [3:0] scal;
    } attr_t;

    typedef struct packed {
        logic              hold;
        logic              pad0;
        logic [1:0]        asel;
        logic              last;
        logic              restart;
        logic [3:0]        pad1;
        logic [NUM_SS-1:0] sel;
        logic [FRAME_W-1:0] data;
    } cmd_t;

    function automatic attr_t word_to_attr(logic [31:0] w);
        attr_t a;
        a.fsz  = w[30:27];
        a.cpol = w[26];
        a.cpha = w[25];
        a.lsb  = w[24];
        a.pre  = w[17:16];
        a.scal = w[3:0];
        return a;
    endfunction

    function automatic logic [31:0] attr_to_word(attr_t a);
        return {1'b0, a.fsz, a.cpol, a.cpha, a.lsb, 6'b0, a.pre, 12'b0, a.scal};
    endfunction

    function automatic logic [HALF_W-1:0] half_period(attr_t a);
        int p;
        int s;
        case (a.pre)
            2'd0:    p = 2;
            2'd1:    p = 3;
            2'd2:    p = 5;
            default: p = 7;
        endcase
        if (a.scal < 4'd4) s = 2 * (int'(a.scal) + 1);
        else               s = 1 << a.scal;
        return HALF_W'((p * s) / 2);
    endfunction

endpackage

// File: rtl/spi_cmdq_fifo.sv
module spi_cmdq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rp;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;
    logic [AW-1:0] wp;

    assign full  = (st_q.cnt == (AW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign rdata = st_q.mem[st_q.rp];
    assign wp    = st_q.rp + st_q.cnt[AW-1:0];

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (flush) begin
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) st_d.mem[wp] = wdata;
            if (do_pop)  st_d.rp = st_q.rp + 1'b1;
            st_d.cnt = st_q.cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (AW+1)'(DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (empty && $stable(st_q.rp)));

endmodule

// File: rtl/spi_cmdq_shifter.sv
module spi_cmdq_shifter
    import spi_cmdq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_data,
    input  attr_t              attr,
    input  logic               miso,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rx_data,
    output logic               sck_o,
    output logic               mosi_o
);
    localparam int EW = $clog2(2 * FRAME_W + 1) + 1;

    typedef struct packed {
        logic               run;
        logic               done;
        logic [HALF_W-1:0]  half;
        logic [HALF_W-1:0]  div;
        logic [EW-1:0]      edges;
        logic               sck;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        attr_t              a;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [3:0]    fsz_eff;
    logic [EW-1:0] edge_total;
    logic [EW-1:0] tx_idx;
    logic [3:0]    rx_pos;
    logic [3:0]    tx_pos;
    logic [HALF_W-1:0] start_half;

    function automatic logic [3:0] bit_pos(logic lsb, logic [3:0] top, logic [3:0] k);
        return lsb ? k : (top - k);
    endfunction

    assign fsz_eff    = (st_q.a.fsz < 4'd3) ? 4'd3 : st_q.a.fsz;
    assign edge_total = EW'({1'b0, fsz_eff} + 5'd1) << 1;
    assign start_half = half_period(attr);

    always_comb begin
        if (st_q.a.cpha) tx_idx = (st_q.edges == '0) ? '0 : ((st_q.edges - 1'b1) >> 1);
        else             tx_idx = st_q.edges >> 1;
    end

    assign tx_pos  = bit_pos(st_q.a.lsb, fsz_eff, tx_idx[3:0]);
    assign rx_pos  = bit_pos(st_q.a.lsb, fsz_eff, st_q.edges[4:1]);
    assign mosi_o  = st_q.run && (tx_idx <= EW'(fsz_eff)) && st_q.tx[tx_pos];
    assign sck_o   = st_q.sck;
    assign busy    = st_q.run;
    assign done    = st_q.done;
    assign rx_data = st_q.rx;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.run) begin
            if (start) begin
                st_d.run   = 1'b1;
                st_d.a     = attr;
                st_d.tx    = tx_data;
                st_d.rx    = '0;
                st_d.edges = '0;
                st_d.sck   = attr.cpol;
                st_d.half  = start_half;
                st_d.div   = start_half - 1'b1;
            end
        end else if (st_q.div != '0) begin
            st_d.div = st_q.div - 1'b1;
        end else begin
            st_d.div = st_q.half - 1'b1;
            if (st_q.edges == edge_total) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.sck   = ~st_q.sck;
                st_d.edges = st_q.edges + 1'b1;
                if (st_q.a.cpha == st_q.edges[0]) st_d.rx[rx_pos] = miso;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !start) |=> $stable(sck_o));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    sck_level_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sck_o == st_q.a.cpol));

endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
    import spi_cmdq_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int CNT_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [5:0]  ss_pin,
    output logic        irq
);
    localparam int NUM_ATTR = 4;

    typedef struct packed {
        logic                        run;
        logic [NUM_SS-1:0]           idle;
        attr_t [NUM_ATTR-1:0]        attrs;
        logic                        ien;
        logic                        flag;
        logic [CNT_W-1:0]            cnt;
        logic                        busy;
        logic [NUM_SS-1:0]           sel;
        logic                        cur_hold;
        logic                        cur_last;
    } top_st_t;

    top_st_t st_d, st_q;

    logic        tx_push, tx_pop, tx_flush, tx_full, tx_empty;
    logic        rx_push, rx_pop, rx_flush, rx_full, rx_empty;
    logic [31:0] tx_head;
    logic [FRAME_W-1:0] rx_head, sh_rx;
    logic        sh_start, sh_busy, sh_done;
    cmd_t        cmd;
    attr_t       cur_attr;

    assign cmd      = cmd_t'(tx_head);
    assign cur_attr = st_q.attrs[cmd.asel];

    spi_cmdq_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata),
        .pop(tx_pop), .flush(tx_flush), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spi_cmdq_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(sh_rx),
        .pop(rx_pop), .flush(rx_flush), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    spi_cmdq_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_data(cmd.data),
        .attr(cur_attr), .miso(miso), .busy(sh_busy), .done(sh_done),
        .rx_data(sh_rx), .sck_o(sck), .mosi_o(mosi)
    );

    always_comb begin
        st_d     = st_q;
        tx_push  = 1'b0;
        tx_pop   = 1'b0;
        tx_flush = 1'b0;
        rx_push  = 1'b0;
        rx_flush = 1'b0;
        sh_start = 1'b0;
        rx_pop   = bus_rd && (bus_addr == A_POP) && !rx_empty;

        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    st_d.run = bus_wdata[31];
                    st_d.idle = bus_wdata[21:16];
                    tx_flush = bus_wdata[11];
                    rx_flush = bus_wdata[10];
                end
                A_STAT:  if (bus_wdata[28]) st_d.flag = 1'b0;
                A_IEN:   st_d.ien = bus_wdata[28];
                A_PUSH:  tx_push = 1'b1;
                default: begin
                    for (int i = 0; i < NUM_ATTR; i++) begin
                        if (bus_addr == A_ATTR0 + 8'(4 * i))
                            st_d.attrs[i] = word_to_attr(bus_wdata);
                    end
                end
            endcase
        end

        if (!st_q.busy) begin
            if (st_q.run && !st_q.flag && !tx_empty && !rx_full && !sh_busy) begin
                tx_pop        = 1'b1;
                sh_start      = 1'b1;
                st_d.busy     = 1'b1;
                st_d.sel      = cmd.sel;
                st_d.cur_hold = cmd.hold;
                st_d.cur_last = cmd.last;
                if (cmd.restart) st_d.cnt = '0;
            end
        end else if (sh_done) begin
            rx_push   = 1'b1;
            st_d.busy = 1'b0;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cur_last) st_d.flag = 1'b1;
            if (!st_q.cur_hold || st_q.cur_last) st_d.sel = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.idle <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {st_q.run, 9'b0, st_q.idle, 16'b0};
            A_STAT: bus_rdata = {3'b0, st_q.flag, 12'b0, st_q.cnt};
            A_IEN:  bus_rdata = {3'b0, st_q.ien, 28'b0};
            A_POP:  bus_rdata = rx_empty ? 32'b0 : {16'b0, rx_head};
            default: begin
                for (int i = 0; i < NUM_ATTR; i++) begin
                    if (bus_addr == A_ATTR0 + 8'(4 * i))
                        bus_rdata = attr_to_word(st_q.attrs[i]);
                end
            end
        endcase
    end

    assign ss_pin = st_q.idle ^ st_q.sel;
    assign irq    = st_q.flag & st_q.ien;

    // R6
    eoq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(sh_done));

    // R6
    eoq_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> !sh_start);

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_start && !sh_done) |=> $stable(st_q.sel));

    // R10
    rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !rx_full);

endmodule

// File: tb/tb_spi_cmdq_master.sv
module tb_spi_cmdq_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        sck, mosi;
    logic        miso = 1'b0;
    logic [5:0]  ss_pin;
    logic        irq;

    always #5 clk = ~clk;

    spi_cmdq_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_pin(ss_pin), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int       cur_n = 8;
    logic     cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
    logic [5:0] idle_cfg = 6'h3F;
    logic [5:0] exp_ss = 6'h3E;

    logic [15:0] exp_tx_q[$];
    logic [15:0] rx_exp_q[$];
    int k_frames = 0;
    int falls = 0;
    int gap = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fmask(int n);
        return 16'((32'h1 << n) - 1);
    endfunction

    function automatic logic [15:0] slave_word(int k);
        return 16'(32'h5A3C ^ (k * 32'h0F1D));
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Slave model and scoreboard monitor
    int bi = 0;
    logic [15:0] cap = 0;
    logic act_prev = 0, sck_prev = 0, edge_valid = 0;
    int last_edge = 0;
    always @(negedge clk) begin
        logic act, edge_now, lead;
        int pos;
        logic [15:0] e;
        act = (ss_pin != idle_cfg);
        edge_now = act && act_prev && (sck != sck_prev);
        if (!act) begin bi = 0; edge_valid = 0; end
        if (act_prev && !act) falls++;
        if (edge_now) begin
            if (edge_valid) gap = cyc - last_edge;
            last_edge = cyc;
            edge_valid = 1;
            lead = (sck != cur_cpol);
            pos = cur_lsb ? bi : cur_n - 1 - bi;
            if (lead != cur_cpha) cap[pos] = mosi;
            if (!lead) begin
                bi++;
                if (bi == cur_n) begin
                    e = (exp_tx_q.size() > 0) ? exp_tx_q.pop_front() : 16'hDEAD;
                    chk(cap == e, "R2 mosi frame", int'(cap), int'(e));
                    chk(ss_pin == exp_ss, "R4 select", int'(ss_pin), int'(exp_ss));
                    rx_exp_q.push_back(slave_word(k_frames) & fmask(cur_n));
                    k_frames++;
                    bi = 0;
                    cap = 0;
                end
            end
        end
        pos = cur_lsb ? bi : cur_n - 1 - bi;
        miso = act ? slave_word(k_frames)[pos] : 1'b0;
        act_prev = act;
        sck_prev = sck;
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic set_attr(int idx, int fsz, logic cp, logic ph, logic lsb, int pre, int scal);
        wr(8'(12 + 4 * idx), {1'b0, 4'(fsz), cp, ph, lsb, 6'b0, 2'(pre), 12'b0, 4'(scal)});
        cur_n = fsz + 1; cur_cpol = cp; cur_cpha = ph; cur_lsb = lsb;
    endtask

    task automatic push_cmd(logic hold, int asel, logic last, logic rst_cnt,
                            logic [5:0] sel, logic [15:0] data, bit expect_it);
        wr(8'h34, {hold, 1'b0, 2'(asel), last, rst_cnt, 4'b0, sel, data});
        if (expect_it) exp_tx_q.push_back(data & fmask(cur_n));
    endtask

    task automatic wait_flag(string req);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h2C, v);
            if (v[28]) return;
        end
        chk(0, req, 0, 1);
    endtask

    task automatic pop_chk(string req);
        logic [31:0] v;
        logic [15:0] e;
        rd(8'h38, v);
        e = (rx_exp_q.size() > 0) ? rx_exp_q.pop_front() : 16'h0;
        chk(v == {16'h0, e}, req, int'(v), int'(e));
    endtask

    task automatic clear_flag();
        wr(8'h2C, 32'h1000_0000);
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, s0;
        int f0, k0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ss_pin == 6'h3F, "R1 ss_pin", int'(ss_pin), 'h3F);
        chk(sck == 1'b0, "R1 sck", int'(sck), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        rd(8'h2C, v);
        chk(v == 0, "R1 status", int'(v), 0);

        wr(8'h00, 32'h803F_0000);
        wr(8'h30, 32'h1000_0000);
        set_attr(0, 7, 0, 0, 0, 0, 0);

        // R5 R6 R7 R8: held select, end of queue, counter restart
        exp_ss = 6'h3E;
        f0 = falls;
        push_cmd(1, 0, 0, 1, 6'h01, 16'h12A5, 1);
        push_cmd(1, 0, 0, 0, 6'h01, 16'h003C, 1);
        push_cmd(1, 0, 1, 0, 6'h01, 16'hFF81, 1);
        wait_flag("R6 flag set");
        chk(falls - f0 == 1, "R5 held select releases once", falls - f0, 1);
        chk(irq == 1, "R7 irq on", int'(irq), 1);
        rd(8'h2C, v);
        chk(v == 32'h1000_0003, "R8 count after restart", int'(v), 'h10000003);
        chk(sck == 0, "R3 cpol0 rest", int'(sck), 0);
        for (int i = 0; i < 3; i++) pop_chk("R2 rx data");
        clear_flag();
        chk(irq == 0, "R7 irq off", int'(irq), 0);
        rd(8'h2C, v);
        chk(v[28] == 0, "R6 w1c", int'(v[28]), 0);

        // R5 per-frame release
        f0 = falls;
        push_cmd(0, 0, 0, 0, 6'h01, 16'h0011, 1);
        push_cmd(0, 0, 1, 0, 6'h01, 16'h0022, 1);
        wait_flag("R6 flag set");
        chk(falls - f0 == 2, "R5 per-frame release", falls - f0, 2);
        rd(8'h2C, v);
        chk(v[15:0] == 5, "R8 count continues", int'(v[15:0]), 5);
        pop_chk("R2 rx data"); pop_chk("R2 rx data");
        clear_flag();

        // R3 R4 modes, lengths, bit order, attribute choice, idle level
        for (int m = 1; m < 4; m++) begin
            case (m)
                1: set_attr(1, 15, 1, 1, 1, 0, 0);
                2: set_attr(2, 3, 0, 1, 0, 0, 0);
                default: begin
                    set_attr(3, 11, 1, 0, 1, 0, 0);
                    wr(8'h00, 32'h8000_0000);
                    idle_cfg = 6'h00;
                    idle_cycles(2);
                end
            endcase
            exp_ss = idle_cfg ^ (6'h1 << (m + 1));
            push_cmd(1, m, 0, 1, 6'h1 << (m + 1), 16'hC3A5 + 16'(m), 1);
            push_cmd(0, m, 1, 0, 6'h1 << (m + 1), 16'h1E96 - 16'(m), 1);
            wait_flag("R6 flag set");
            chk(sck == cur_cpol, "R3 cpol rest level", int'(sck), int'(cur_cpol));
            chk(ss_pin == idle_cfg, "R4 select idle", int'(ss_pin), int'(idle_cfg));
            rd(8'h2C, v);
            chk(v[15:0] == 2, "R8 count", int'(v[15:0]), 2);
            pop_chk("R2 rx data"); pop_chk("R2 rx data");
            clear_flag();
        end
        wr(8'h00, 32'h803F_0000);
        idle_cfg = 6'h3F;
        set_attr(0, 7, 0, 0, 0, 0, 0);
        exp_ss = 6'h3E;
        idle_cycles(2);

        // R6 halt after end of queue
        k0 = k_frames;
        push_cmd(0, 0, 1, 0, 6'h01, 16'h0055, 1);
        push_cmd(0, 0, 1, 0, 6'h01, 16'h00AA, 1);
        wait_flag("R6 flag set");
        idle_cycles(200);
        chk(k_frames - k0 == 1, "R6 halted", k_frames - k0, 1);
        clear_flag();
        wait_flag("R6 flag set");
        chk(k_frames - k0 == 2, "R6 resumes", k_frames - k0, 2);
        pop_chk("R2 rx data"); pop_chk("R2 rx data");
        clear_flag();

        // R9 R11 full transmit FIFO and run gate
        wr(8'h00, 32'h003F_0000);
        k0 = k_frames;
        for (int i = 0; i < 4; i++) push_cmd(0, 0, i == 3, i == 0, 6'h01, 16'(i * 37 + 5), 1);
        push_cmd(0, 0, 1, 0, 6'h01, 16'h00EE, 0);
        idle_cycles(300);
        chk(k_frames == k0, "R11 run gate", k_frames - k0, 0);
        wr(8'h00, 32'h803F_0000);
        wait_flag("R6 flag set");
        clear_flag();
        idle_cycles(300);
        chk(k_frames - k0 == 4, "R9 fifth dropped", k_frames - k0, 4);
        rd(8'h2C, v);
        chk(v[15:0] == 4, "R9 count", int'(v[15:0]), 4);
        for (int i = 0; i < 4; i++) pop_chk("R2 rx data");

        // R10 receive full stall and empty pop
        k0 = k_frames;
        for (int i = 0; i < 4; i++) push_cmd(0, 0, 0, 0, 6'h01, 16'(i + 200), 1);
        idle_cycles(400);
        push_cmd(0, 0, 1, 0, 6'h01, 16'h0077, 1);
        idle_cycles(400);
        chk(k_frames - k0 == 4, "R10 stall on full", k_frames - k0, 4);
        pop_chk("R10 rx data");
        wait_flag("R6 flag set");
        chk(k_frames - k0 == 5, "R10 resumes", k_frames - k0, 5);
        for (int i = 0; i < 4; i++) pop_chk("R10 rx data");
        rd(8'h2C, s0);
        rd(8'h38, v);
        chk(v == 0, "R10 empty pop zero", int'(v), 0);
        rd(8'h2C, v);
        chk(v == s0, "R10 empty pop no change", int'(v), int'(s0));
        clear_flag();

        // R11 flush strobes
        wr(8'h00, 32'h003F_0000);
        k0 = k_frames;
        push_cmd(0, 0, 1, 0, 6'h01, 16'h0101, 0);
        push_cmd(0, 0, 1, 0, 6'h01, 16'h0202, 0);
        wr(8'h00, 32'h803F_0800);
        idle_cycles(300);
        chk(k_frames == k0, "R11 tx flush", k_frames - k0, 0);
        push_cmd(0, 0, 1, 0, 6'h01, 16'h0033, 1);
        wait_flag("R6 flag set");
        clear_flag();
        wr(8'h00, 32'h803F_0400);
        rx_exp_q.delete();
        rd(8'h38, v);
        chk(v == 0, "R11 rx flush", int'(v), 0);

        // R12 bit rate: pre code 1 (3), scaler code 1 (4) gives half period 6
        set_attr(0, 7, 0, 0, 0, 1, 1);
        push_cmd(0, 0, 1, 0, 6'h01, 16'h00C7, 1);
        wait_flag("R6 flag set");
        chk(gap == 6, "R12 half period", gap, 6);
        pop_chk("R2 rx data");
        clear_flag();

        chk(exp_tx_q.size() == 0, "R2 all frames seen", exp_tx_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule